// File: doc/BRIEF.md
# Page Access Check and Fault Capture Unit

This block sits between the address generator of a processor and its translation lookup. Each request carries a virtual address, an access kind (instruction fetch, data read or data write) and the privilege of the requester. Two page entries arrive alongside it, one from the kernel translation set and one from the user translation set. The top bit of the virtual address picks which of the two is used. The block checks the chosen entry's permission flags against the access. It then does one of two things one cycle later: it returns the physical address, or it reports a fault with a cause code.

On every fault the block captures the offending virtual address and the cause, and it marks the processor as being inside a handler. A further fault taken while that mark is set is reported as a double fault. The mark is cleared by an exception-return strobe. An optional mode turns address translation off when a fault is taken, so that the handler runs on physical addresses. Software turns translation back on through a write strobe. While translation is off, addresses pass straight through and nothing faults.

Top module: `xlat_guard`

## Requirements
- R1: A request presented with `req_valid` high yields `resp_valid` high on the following cycle. A cycle with `req_valid` low yields `resp_valid`, `resp_fault` and `resp_cause` at 0 on the following cycle.
- R2: The kernel set (`kern_flags`, `kern_frame`) is used when the top virtual address bit is 1, and the user set otherwise. A permitted access returns `resp_paddr` = {frame, low OFF_W bits of the address}.
- R3: The flag bits are bit0 present, bit1 writable, bit2 executable and bit3 user-accessible. The access kinds are 0 fetch, 1 read, 2 write, and 3 is treated as a read. The cause is 1 when the page is not present, 4 when a user access (`req_user`=1) targets a page without the user bit, 2 when a write targets a page without the writable bit, and 3 when a fetch targets a page without the executable bit. The first of these that applies, in that order, wins. The cause is 0 with `resp_fault` low when none applies, and `resp_paddr` is 0 on a fault.
- R4: A fault taken while `in_handler` is 1 is reported with cause 5 on both `resp_cause` and `fault_cause`.
- R5: On every fault, `fault_addr` takes the request's virtual address and `fault_cause` takes the reported cause. This holds for fetches and data accesses alike. Both registers stay unchanged on all other cycles.
- R6: No history is kept. Repeating a request to a page whose entry still fails faults again each time with the same cause.
- R7: A fault sets `in_handler`. An `exc_ret` strobe clears it on a cycle with no fault, and a fault in the same cycle takes precedence.
- R8: When `trap_xlat_off` is 1, a fault clears `xlat_en`. A `xlat_wr` strobe loads `xlat_en` from `xlat_wr_val`, but a fault clearing `xlat_en` in the same cycle takes precedence.
- R9: While `xlat_en` is 0, a request returns `resp_paddr` equal to the zero-extended virtual address and never faults. The fault registers are left untouched.
- R10: After reset `xlat_en` is 1, and `in_handler`, `fault_addr`, `fault_cause` and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_vaddr | input | VA_W | Virtual address of the access |
| req_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| req_user | input | 1 | 1 for a user-mode access |
| kern_flags | input | 4 | Kernel-set entry flags |
| kern_frame | input | PFN_W | Kernel-set physical frame |
| user_flags | input | 4 | User-set entry flags |
| user_frame | input | PFN_W | User-set physical frame |
| trap_xlat_off | input | 1 | Mode: turn translation off on fault entry |
| exc_ret | input | 1 | Exception-return strobe |
| xlat_wr | input | 1 | Software write strobe for the translation enable |
| xlat_wr_val | input | 1 | Value written to the translation enable |
| resp_valid | output | 1 | Response present |
| resp_fault | output | 1 | Response is a fault |
| resp_cause | output | 3 | Fault cause of the response |
| resp_paddr | output | PA_W | Physical address of the response |
| fault_addr | output | VA_W | Captured faulting virtual address |
| fault_cause | output | 3 | Captured fault cause |
| in_handler | output | 1 | A fault is being handled |
| xlat_en | output | 1 | Translation enable |

## Verification
The bench sweeps every combination of access kind, privilege, flag pattern and translation set. The set not in use is given the inverted flags, so a mux that picks the wrong set, or a priority chain in the wrong order, shows up as a wrong cause or a wrong frame. Dedicated sequences go after nested faults, which a design without escalation would report as an ordinary cause. They check that a non-faulting access inside a handler leaves the captured address alone, where a design that loads on every request would overwrite it. They also check that a repeated access to a still-broken page faults again, where a design that remembers faults would not. The trap mode is driven into pass-through and then restored by a software write. A design that kept translating there would return a framed address, or a fault, instead of the raw address.

// File: rtl/xg_pkg.sv
package xg_pkg;
    localparam int FLAG_W  = 4;
    localparam int CAUSE_W = 3;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef enum logic [CAUSE_W-1:0] {
        C_NONE   = 3'd0,
        C_ABSENT = 3'd1,
        C_WPROT  = 3'd2,
        C_NOEXEC = 3'd3,
        C_PRIV   = 3'd4,
        C_DOUBLE = 3'd5
    } cause_e;

    typedef struct packed {
        logic usr;
        logic ex;
        logic wr;
        logic present;
    } pflags_t;
endpackage

// File: rtl/xg_set_mux.sv
module xg_set_mux #(
    parameter int PFN_W = 8
) (
    input  logic                      vaddr_top,
    input  logic [xg_pkg::FLAG_W-1:0] kern_flags,
    input  logic [PFN_W-1:0]          kern_frame,
    input  logic [xg_pkg::FLAG_W-1:0] user_flags,
    input  logic [PFN_W-1:0]          user_frame,
    output xg_pkg::pflags_t           sel_flags,
    output logic [PFN_W-1:0]          sel_frame
);
    // Kernel range is the upper half of the virtual space.
    always_comb begin
        if (vaddr_top) begin
            sel_flags = xg_pkg::pflags_t'(kern_flags);
            sel_frame = kern_frame;
        end else begin
            sel_flags = xg_pkg::pflags_t'(user_flags);
            sel_frame = user_frame;
        end
    end
endmodule

// File: rtl/xg_perm_check.sv
module xg_perm_check (
    input  xg_pkg::kind_e   kind,
    input  logic            is_user,
    input  xg_pkg::pflags_t flags,
    output xg_pkg::cause_e  cause
);
    import xg_pkg::*;

    always_comb begin
        cause = C_NONE;
        if (!flags.present) begin
            cause = C_ABSENT;
        end else if (is_user && !flags.usr) begin
            cause = C_PRIV;
        end else if (kind == KIND_WRITE && !flags.wr) begin
            cause = C_WPROT;
        end else if (kind == KIND_FETCH && !flags.ex) begin
            cause = C_NOEXEC;
        end
    end
endmodule

// File: rtl/xg_fault_state.sv
module xg_fault_state #(
    parameter int   VA_W        = 16,
    parameter logic RST_XLAT_EN = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [VA_W-1:0]            req_vaddr,
    input  xg_pkg::cause_e             raw_cause,
    input  logic                       trap_xlat_off,
    input  logic                       exc_ret,
    input  logic                       xlat_wr,
    input  logic                       xlat_wr_val,
    output logic                       fault_take,
    output xg_pkg::cause_e             eff_cause,
    output logic [VA_W-1:0]            fault_addr,
    output logic [xg_pkg::CAUSE_W-1:0] fault_cause,
    output logic                       in_handler,
    output logic                       xlat_en
);
    import xg_pkg::*;

    typedef struct packed {
        logic [VA_W-1:0] addr;
        cause_e          cause;
        logic            inh;
        logic            en;
    } fst_t;

    fst_t st_d, st_q;

    always_comb begin
        fault_take = req_valid && st_q.en && (raw_cause != C_NONE);
        eff_cause  = st_q.inh ? C_DOUBLE : raw_cause;
        st_d       = st_q;
        if (xlat_wr) begin
            st_d.en = xlat_wr_val;
        end
        if (fault_take) begin
            st_d.addr  = req_vaddr;
            st_d.cause = eff_cause;
            st_d.inh   = 1'b1;
            if (trap_xlat_off) begin
                st_d.en = 1'b0;
            end
        end else if (exc_ret) begin
            st_d.inh = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.addr  <= '0;
            st_q.cause <= C_NONE;
            st_q.inh   <= 1'b0;
            st_q.en    <= RST_XLAT_EN;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_addr  = st_q.addr;
    assign fault_cause = st_q.cause;
    assign in_handler  = st_q.inh;
    assign xlat_en     = st_q.en;

    p_nested_double_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_take && in_handler) |=> (fault_cause == C_DOUBLE));

    p_capture_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_take |=> ($stable(fault_addr) && $stable(fault_cause)));

    p_capture_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_take |=> (fault_addr == $past(req_vaddr)));

    p_handler_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_take |=> in_handler);

    p_trap_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_take && trap_xlat_off) |=> !xlat_en);
endmodule

// File: rtl/xlat_guard.sv
module xlat_guard #(
    parameter int   VA_W        = 16,
    parameter int   OFF_W       = 10,
    parameter int   PFN_W       = 8,
    parameter logic RST_XLAT_EN = 1'b1,
    localparam int  PA_W        = PFN_W + OFF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [VA_W-1:0]            req_vaddr,
    input  logic [1:0]                 req_kind,
    input  logic                       req_user,
    input  logic [xg_pkg::FLAG_W-1:0]  kern_flags,
    input  logic [PFN_W-1:0]           kern_frame,
    input  logic [xg_pkg::FLAG_W-1:0]  user_flags,
    input  logic [PFN_W-1:0]           user_frame,
    input  logic                       trap_xlat_off,
    input  logic                       exc_ret,
    input  logic                       xlat_wr,
    input  logic                       xlat_wr_val,
    output logic                       resp_valid,
    output logic                       resp_fault,
    output logic [xg_pkg::CAUSE_W-1:0] resp_cause,
    output logic [PA_W-1:0]            resp_paddr,
    output logic [VA_W-1:0]            fault_addr,
    output logic [xg_pkg::CAUSE_W-1:0] fault_cause,
    output logic                       in_handler,
    output logic                       xlat_en
);
    import xg_pkg::*;

    typedef struct packed {
        logic            valid;
        logic            fault;
        cause_e          cause;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    pflags_t          sel_flags;
    logic [PFN_W-1:0] sel_frame;
    cause_e           raw_cause;
    cause_e           eff_cause;
    logic             fault_take;
    rsp_t             rsp_d, rsp_q;

    xg_set_mux #(.PFN_W(PFN_W)) u_mux (
        .vaddr_top (req_vaddr[VA_W-1]),
        .kern_flags(kern_flags),
        .kern_frame(kern_frame),
        .user_flags(user_flags),
        .user_frame(user_frame),
        .sel_flags (sel_flags),
        .sel_frame (sel_frame)
    );

    xg_perm_check u_chk (
        .kind   (kind_e'(req_kind)),
        .is_user(req_user),
        .flags  (sel_flags),
        .cause  (raw_cause)
    );

    xg_fault_state #(.VA_W(VA_W), .RST_XLAT_EN(RST_XLAT_EN)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .raw_cause    (raw_cause),
        .trap_xlat_off(trap_xlat_off),
        .exc_ret      (exc_ret),
        .xlat_wr      (xlat_wr),
        .xlat_wr_val  (xlat_wr_val),
        .fault_take   (fault_take),
        .eff_cause    (eff_cause),
        .fault_addr   (fault_addr),
        .fault_cause  (fault_cause),
        .in_handler   (in_handler),
        .xlat_en      (xlat_en)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (!xlat_en) begin
                rsp_d.paddr = PA_W'(req_vaddr);
            end else if (fault_take) begin
                rsp_d.fault = 1'b1;
                rsp_d.cause = eff_cause;
            end else begin
                rsp_d.paddr = {sel_frame, req_vaddr[OFF_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign resp_valid = rsp_q.valid;
    assign resp_fault = rsp_q.fault;
    assign resp_cause = rsp_q.cause;
    assign resp_paddr = rsp_q.paddr;

    p_resp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !resp_fault));

    p_fault_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (resp_cause != C_NONE && resp_paddr == '0));

    p_off_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlat_en) |=> (!resp_fault && resp_paddr == PA_W'($past(req_vaddr))));
endmodule

// File: tb/xlat_guard_test.sv
`timescale 1ns/1ps
module xlat_guard_test;
    localparam int VA_W  = 16;
    localparam int OFF_W = 10;
    localparam int PFN_W = 8;
    localparam int PA_W  = PFN_W + OFF_W;
    localparam logic [PFN_W-1:0] KFR = 8'hA5;
    localparam logic [PFN_W-1:0] UFR = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic [1:0] req_kind = 2'd0;
    logic req_user = 1'b0;
    logic [3:0] kern_flags = '0;
    logic [PFN_W-1:0] kern_frame = KFR;
    logic [3:0] user_flags = '0;
    logic [PFN_W-1:0] user_frame = UFR;
    logic trap_xlat_off = 1'b0;
    logic exc_ret = 1'b0;
    logic xlat_wr = 1'b0;
    logic xlat_wr_val = 1'b0;
    logic resp_valid, resp_fault;
    logic [2:0] resp_cause, fault_cause;
    logic [PA_W-1:0] resp_paddr;
    logic [VA_W-1:0] fault_addr;
    logic in_handler, xlat_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xlat_guard #(.VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .kern_flags(kern_flags),
        .kern_frame(kern_frame), .user_flags(user_flags), .user_frame(user_frame),
        .trap_xlat_off(trap_xlat_off), .exc_ret(exc_ret), .xlat_wr(xlat_wr),
        .xlat_wr_val(xlat_wr_val), .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_cause(resp_cause), .resp_paddr(resp_paddr), .fault_addr(fault_addr),
        .fault_cause(fault_cause), .in_handler(in_handler), .xlat_en(xlat_en)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] model_cause(logic [1:0] k, logic u, logic [3:0] f);
        if (!f[0]) return 3'd1;
        if (u && !f[3]) return 3'd4;
        if (k == 2'd2 && !f[1]) return 3'd2;
        if (k == 2'd0 && !f[2]) return 3'd3;
        return 3'd0;
    endfunction

    // Called at a negedge; returns at the next negedge with the response visible.
    task automatic access(logic [VA_W-1:0] va, logic [1:0] k, logic u, logic [3:0] kf, logic [3:0] uf);
        req_valid = 1'b1; req_vaddr = va; req_kind = k; req_user = u;
        kern_flags = kf; user_flags = uf;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ret_pulse();
        exc_ret = 1'b1;
        @(negedge clk);
        exc_ret = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        logic [VA_W-1:0] va;
        logic [PA_W-1:0] pa;
        logic [2:0] c;
        logic [2:0] held_c;
        logic [VA_W-1:0] held_a;
        int idx;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 xlat_en", 32'(xlat_en), 1);
        chk("R10 in_handler", 32'(in_handler), 0);
        chk("R10 fault_addr", 32'(fault_addr), 0);
        chk("R10 fault_cause", 32'(fault_cause), 0);
        chk("R10 resp_valid", 32'(resp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle resp_valid", 32'(resp_valid), 0);

        // R2 R3 R5 R7 sweep
        idx = 0;
        for (int k = 0; k < 3; k++) begin
            for (int u = 0; u < 2; u++) begin
                for (int f = 0; f < 16; f++) begin
                    for (int s = 0; s < 2; s++) begin
                        idx++;
                        va = {s[0], 15'(idx * 37 + 5)};
                        c = model_cause(k[1:0], u[0], f[3:0]);
                        pa = {(s == 1) ? KFR : UFR, va[OFF_W-1:0]};
                        if (s == 1) access(va, k[1:0], u[0], f[3:0], ~f[3:0]);
                        else        access(va, k[1:0], u[0], ~f[3:0], f[3:0]);
                        chk("R1 resp_valid", 32'(resp_valid), 1);
                        chk("R3 resp_fault", 32'(resp_fault), 32'(c != 0));
                        chk("R3 resp_cause", 32'(resp_cause), 32'(c));
                        chk("R2 resp_paddr", 32'(resp_paddr), (c != 0) ? 0 : 32'(pa));
                        if (c != 0) begin
                            chk("R5 fault_addr", 32'(fault_addr), 32'(va));
                            chk("R5 fault_cause", 32'(fault_cause), 32'(c));
                            chk("R7 in_handler set", 32'(in_handler), 1);
                            ret_pulse();
                            chk("R7 in_handler cleared", 32'(in_handler), 0);
                        end
                    end
                end
            end
        end
        @(negedge clk);
        chk("R1 idle after sweep", 32'(resp_valid), 0);

        // R4 nested fault, R5 fetch captures its own address
        access(16'h1111, 2'd0, 1'b0, 4'hF, 4'b1011);
        chk("R3 fetch noexec", 32'(resp_cause), 3);
        chk("R5 fetch fault_addr", 32'(fault_addr), 32'h1111);
        access(16'h9222, 2'd1, 1'b0, 4'h0, 4'hF);
        chk("R4 double resp_cause", 32'(resp_cause), 5);
        chk("R4 double fault_cause", 32'(fault_cause), 5);
        chk("R5 double fault_addr", 32'(fault_addr), 32'h9222);
        held_a = fault_addr; held_c = fault_cause;
        access(16'h0333, 2'd1, 1'b0, 4'h0, 4'hF);
        chk("R5 hold addr on good access", 32'(fault_addr), 32'(held_a));
        chk("R5 hold cause on good access", 32'(fault_cause), 32'(held_c));
        chk("R7 still in handler", 32'(in_handler), 1);
        // R7 fault wins over exc_ret in the same cycle
        exc_ret = 1'b1;
        access(16'h0444, 2'd2, 1'b0, 4'hF, 4'b1101);
        exc_ret = 1'b0;
        chk("R7 fault over ret", 32'(in_handler), 1);
        chk("R4 double with ret", 32'(resp_cause), 5);
        ret_pulse();
        chk("R7 ret clears", 32'(in_handler), 0);

        // R6 no history
        for (int r = 0; r < 3; r++) begin
            access(16'h8555, 2'd2, 1'b1, 4'b0101, 4'hF);
            chk("R6 repeat fault", 32'(resp_cause), 4);
            ret_pulse();
        end

        // R8 trap mode, R9 pass-through
        trap_xlat_off = 1'b1;
        access(16'h8666, 2'd1, 1'b0, 4'h0, 4'h0);
        chk("R8 fault cause", 32'(resp_cause), 1);
        chk("R8 xlat_en cleared", 32'(xlat_en), 0);
        held_a = fault_addr; held_c = fault_cause;
        access(16'h8777, 2'd0, 1'b1, 4'h0, 4'h0);
        chk("R9 no fault", 32'(resp_fault), 0);
        chk("R9 raw paddr", 32'(resp_paddr), 32'h8777);
        chk("R9 fault_addr untouched", 32'(fault_addr), 32'(held_a));
        chk("R9 fault_cause untouched", 32'(fault_cause), 32'(held_c));
        // R8 fault beats a software re-enable in the same cycle
        trap_xlat_off = 1'b0;
        xlat_wr = 1'b1; xlat_wr_val = 1'b1;
        @(negedge clk);
        xlat_wr = 1'b0;
        chk("R8 sw re-enable", 32'(xlat_en), 1);
        ret_pulse();
        trap_xlat_off = 1'b1;
        xlat_wr = 1'b1; xlat_wr_val = 1'b1;
        access(16'h0888, 2'd1, 1'b0, 4'h0, 4'h0);
        xlat_wr = 1'b0;
        chk("R8 fault over sw write", 32'(xlat_en), 0);
        trap_xlat_off = 1'b0;
        xlat_wr = 1'b1; xlat_wr_val = 1'b1;
        @(negedge clk);
        xlat_wr = 1'b0;
        ret_pulse();
        access(16'h0999, 2'd1, 1'b0, 4'h0, 4'h1);
        chk("R2 translated again", 32'(resp_paddr), 32'({UFR, 10'h199}));

        done = 1'b1;
        summary();
    end
endmodule